// File: doc/BRIEF.md
# SPI Status and Interrupt Flag Unit

This block keeps the three status flags of an SPI peripheral that has transmit and receive buffers. It also drives the peripheral's interrupt request and holds the double-speed control bit. The flags are a transfer-completion flag, a transmit-buffer level flag and a receive-buffer level flag. The serial shifter, the buffers and the clock divider sit outside. The block only sees the fill counts of the buffers, pulses for finished transfers, the chip-select situation, and the CPU's read and write strobes for the status and data registers.

The completion flag is kept by a three-state machine:

- `CF_IDLE`: the flag is clear.
- `CF_PEND`: the flag is set and no clear is armed.
- `CF_ARMED`: the flag is set and a status read has armed the two-step clear.

Transitions:

- `CF_IDLE` to `CF_PEND` on a set event.
- `CF_PEND` to `CF_ARMED` on a status read.
- `CF_PEND` to `CF_IDLE` on an interrupt acknowledge without a set event.
- `CF_ARMED` to `CF_IDLE` on a data access or an acknowledge without a set event.
- `CF_ARMED` to `CF_PEND` when a clear and a set event meet in one cycle.

Each buffer flag is a two-state machine:

- `LV_QUIET` to `LV_RAISED` when the fill equals the threshold.
- `LV_RAISED` to `LV_QUIET` when its clear condition holds and the fill does not equal the threshold.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset the status value is 0x00. Bit 7 is the completion flag, bit 5 the transmit flag, bit 3 the receive flag and bit 0 the double-speed bit; bits 6, 4, 2 and 1 always read 0.
- R2: A `xfer_done` pulse sets the completion flag (status bit 7) after the next clock edge.
- R3: The completion flag also sets in a cycle where `host_mode`=1, `cs_as_input`=1 and `cs_level`=0. A low `cs_level` outside host mode does not set it.
- R4: An `int_ack` pulse clears the completion flag.
- R5: A data access (`dat_rd` or `dat_wr`) clears the completion flag only after a status read taken while the flag was set. A data access without such a read leaves the flag at 1. Clearing the flag by acknowledge drops the arming.
- R6: A set event in the same cycle as any clear of the completion flag leaves the flag set.
- R7: The transmit flag (bit 5) sets when `tx_fill` equals `tx_thr`. It stays set until a cycle with `dat_wr`=1 and `tx_fill` greater than `tx_thr`, which clears it.
- R8: The receive flag (bit 3) sets when `rx_fill` equals `rx_thr`. It stays set until a cycle with `dat_rd`=1 and `rx_fill` less than `rx_thr`, which clears it.
- R9: `irq` is 1 only when `spie`=1, `gie`=1 and at least one of the three flags is set.
- R10: A status write loads `ds_wdata` into bit 0, which is the only writable bit. `dbl_speed` is that bit ANDed with `host_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_done | input | 1 | One-cycle pulse at the end of a serial transfer |
| host_mode | input | 1 | Peripheral runs as bus host |
| cs_as_input | input | 1 | Chip-select pin is configured as an input |
| cs_level | input | 1 | Level on the chip-select pin |
| tx_fill | input | FILL_W | Transmit buffer fill count |
| rx_fill | input | FILL_W | Receive buffer fill count |
| tx_thr | input | THR_W | Transmit flag threshold |
| rx_thr | input | THR_W | Receive flag threshold |
| sts_rd | input | 1 | CPU reads the status register |
| sts_wr | input | 1 | CPU writes the status register |
| ds_wdata | input | 1 | Write data for the double-speed bit |
| dat_rd | input | 1 | CPU reads the data register |
| dat_wr | input | 1 | CPU writes the data register |
| int_ack | input | 1 | Completion interrupt acknowledged |
| spie | input | 1 | Peripheral interrupt enable |
| gie | input | 1 | Global interrupt enable |
| sts_rdata | output | 8 | Status register read value |
| irq | output | 1 | Interrupt request |
| dbl_speed | output | 1 | Double-speed control active |

## Verification
The hardest situations to reach are the ones where arming and set events overlap:

- A set event lands in the same cycle as the arming data access.
- An arming made before an acknowledge must not survive into the next flag period.

The stimulus first arms the flag with a status read. It then issues a data write together with a new transfer pulse, and checks that the flag stays set and a plain data access no longer clears it. A second sequence arms, clears by acknowledge, sets again and checks that a lone data read leaves the flag set.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_PEND  = 2'd1,
        CF_ARMED = 2'd2
    } cf_state_t;

    typedef enum logic {
        LV_QUIET  = 1'b0,
        LV_RAISED = 1'b1
    } lv_state_t;

    localparam int STS_W      = 8;
    localparam int BIT_CF     = 7;
    localparam int BIT_TX     = 5;
    localparam int BIT_RX     = 3;
    localparam int BIT_DS     = 0;

endpackage

// File: rtl/spi_cmpl_fsm.sv
module spi_cmpl_fsm
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic sts_rd,
    input  logic dat_acc,
    input  logic int_ack,
    output logic cf_flag
);

    cf_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CF_IDLE: begin
                if (set_ev) state_d = CF_PEND;
            end
            CF_PEND: begin
                if (int_ack && !set_ev) state_d = CF_IDLE;
                else if (sts_rd && !int_ack) state_d = CF_ARMED;
            end
            CF_ARMED: begin
                if (int_ack || dat_acc) state_d = set_ev ? CF_PEND : CF_IDLE;
            end
            default: state_d = CF_IDLE;
        endcase
    end

    always_comb begin
        cf_flag = (state_q != CF_IDLE);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> cf_flag); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !set_ev) |=> !cf_flag); // R4

    AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CF_PEND && !int_ack) |=> cf_flag); // R5

endmodule

// File: rtl/spi_lvl_flag.sv
module spi_lvl_flag
    import spi_stat_pkg::*;
#(
    parameter int FILL_W    = 4,
    parameter int THR_W     = 3,
    parameter bit CLR_ABOVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [THR_W-1:0]  thr,
    input  logic              access,
    output logic              flag
);

    localparam int PAD_W = FILL_W - THR_W;

    lv_state_t   state_q, state_d;
    logic [FILL_W-1:0] thr_x;
    logic        hit;
    logic        clr;

    assign thr_x = {{PAD_W{1'b0}}, thr};
    assign hit   = (fill == thr_x);

    generate
        if (CLR_ABOVE) begin : g_clr_above
            assign clr = access && (fill > thr_x);
        end else begin : g_clr_below
            assign clr = access && (fill < thr_x);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_QUIET:  if (hit) state_d = LV_RAISED;
            LV_RAISED: if (clr && !hit) state_d = LV_QUIET;
            default:   state_d = LV_QUIET;
        endcase
    end

    always_comb begin
        flag = (state_q == LV_RAISED);
    end

    AST_LVL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R7 R8

    AST_LVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !access) |=> flag); // R7 R8

endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
    import spi_stat_pkg::*;
#(
    parameter int FILL_W = 4,
    parameter int THR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic              host_mode,
    input  logic              cs_as_input,
    input  logic              cs_level,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic              sts_rd,
    input  logic              sts_wr,
    input  logic              ds_wdata,
    input  logic              dat_rd,
    input  logic              dat_wr,
    input  logic              int_ack,
    input  logic              spie,
    input  logic              gie,
    output logic [STS_W-1:0]  sts_rdata,
    output logic              irq,
    output logic              dbl_speed
);

    logic cs_fault;
    logic set_ev;
    logic cf_flag, tx_flag, rx_flag;
    logic ds_q;

    assign cs_fault = host_mode && cs_as_input && !cs_level;
    assign set_ev   = xfer_done || cs_fault;

    spi_cmpl_fsm u_cmpl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .sts_rd  (sts_rd),
        .dat_acc (dat_rd || dat_wr),
        .int_ack (int_ack),
        .cf_flag (cf_flag)
    );

    spi_lvl_flag #(.FILL_W(FILL_W), .THR_W(THR_W), .CLR_ABOVE(1'b1)) u_txf (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill   (tx_fill),
        .thr    (tx_thr),
        .access (dat_wr),
        .flag   (tx_flag)
    );

    spi_lvl_flag #(.FILL_W(FILL_W), .THR_W(THR_W), .CLR_ABOVE(1'b0)) u_rxf (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill   (rx_fill),
        .thr    (rx_thr),
        .access (dat_rd),
        .flag   (rx_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ds_q <= 1'b0;
        else if (sts_wr) ds_q <= ds_wdata;
    end

    always_comb begin
        sts_rdata         = '0;
        sts_rdata[BIT_CF] = cf_flag;
        sts_rdata[BIT_TX] = tx_flag;
        sts_rdata[BIT_RX] = rx_flag;
        sts_rdata[BIT_DS] = ds_q;
        irq               = spie && gie && (cf_flag || tx_flag || rx_flag);
        dbl_speed         = ds_q && host_mode;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata[6] == 1'b0) && (sts_rdata[4] == 1'b0) &&
        (sts_rdata[2] == 1'b0) && (sts_rdata[1] == 1'b0)); // R1

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (spie && gie)); // R9

    AST_DS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> $stable(sts_rdata[BIT_DS])); // R10

    AST_XFER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> sts_rdata[BIT_CF]); // R2

endmodule

// File: tb/sim_spi_stat_flags.sv
module sim_spi_stat_flags;

    localparam int FILL_W = 4;
    localparam int THR_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_done = 0, host_mode = 0, cs_as_input = 0, cs_level = 1;
    logic [FILL_W-1:0] tx_fill = '0, rx_fill = '0;
    logic [THR_W-1:0]  tx_thr = 3'd3, rx_thr = 3'd2;
    logic sts_rd = 0, sts_wr = 0, ds_wdata = 0, dat_rd = 0, dat_wr = 0;
    logic int_ack = 0, spie = 0, gie = 0;
    logic [7:0] sts_rdata;
    logic irq, dbl_speed;

    always #5 clk = ~clk;

    spi_stat_flags #(.FILL_W(FILL_W), .THR_W(THR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .host_mode(host_mode),
        .cs_as_input(cs_as_input), .cs_level(cs_level), .tx_fill(tx_fill),
        .rx_fill(rx_fill), .tx_thr(tx_thr), .rx_thr(rx_thr), .sts_rd(sts_rd),
        .sts_wr(sts_wr), .ds_wdata(ds_wdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
        .int_ack(int_ack), .spie(spie), .gie(gie), .sts_rdata(sts_rdata),
        .irq(irq), .dbl_speed(dbl_speed)
    );

    typedef struct {
        logic [7:0] sts;
        logic       irq;
        logic       dbl;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // monitor: compares one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (sts_rdata !== e.sts || irq !== e.irq || dbl_speed !== e.dbl) begin
                    n_fail++;
                    $display("FAIL %s: got sts=%02h irq=%0b dbl=%0b expected sts=%02h irq=%0b dbl=%0b",
                             e.tag, sts_rdata, irq, dbl_speed, e.sts, e.irq, e.dbl);
                end
            end
        end
    end

    // one clock of stimulus, then queue what must be seen after that edge
    task automatic step(input logic [7:0] es, input logic ei, input logic ed, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        xfer_done = 0; sts_rd = 0; sts_wr = 0; dat_rd = 0; dat_wr = 0; int_ack = 0;
        e.sts = es; e.irq = ei; e.dbl = ed; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        step(8'h00, 0, 0, "R1 reset value");

        // R2 completion set; R5 data access without arm keeps it
        xfer_done = 1;             step(8'h80, 0, 0, "R2 transfer sets flag");
        dat_rd = 1;                step(8'h80, 0, 0, "R5 unarmed data read ignored");
        sts_rd = 1;                step(8'h80, 0, 0, "R5 status read arms");
        dat_rd = 1;                step(8'h00, 0, 0, "R5 armed data read clears");

        // R4 acknowledge
        xfer_done = 1;             step(8'h80, 0, 0, "R2 set again");
        int_ack = 1;               step(8'h00, 0, 0, "R4 ack clears");

        // R6 set beats armed clear, arming dropped
        xfer_done = 1;             step(8'h80, 0, 0, "R2 set");
        sts_rd = 1;                step(8'h80, 0, 0, "R5 arm");
        dat_wr = 1; xfer_done = 1; step(8'h80, 0, 0, "R6 set wins over clear");
        dat_rd = 1;                step(8'h80, 0, 0, "R6 new set needs new arm");
        sts_rd = 1;                step(8'h80, 0, 0, "R5 re-arm");
        dat_wr = 1;                step(8'h00, 0, 0, "R5 data write clears");

        // R5 arming lost across acknowledge
        xfer_done = 1;             step(8'h80, 0, 0, "R2 set");
        sts_rd = 1;                step(8'h80, 0, 0, "R5 arm");
        int_ack = 1;               step(8'h00, 0, 0, "R4 ack clears armed");
        xfer_done = 1;             step(8'h80, 0, 0, "R2 set after ack");
        dat_rd = 1;                step(8'h80, 0, 0, "R5 stale arm not kept");
        int_ack = 1;               step(8'h00, 0, 0, "R4 ack");

        // R3 chip-select fault
        cs_as_input = 1; cs_level = 0;
        step(8'h00, 0, 0, "R3 low cs outside host mode ignored");
        host_mode = 1;             step(8'h80, 0, 0, "R3 host fault sets");
        cs_level = 1; int_ack = 1; step(8'h00, 0, 0, "R4 ack after fault");
        host_mode = 0; cs_as_input = 0;

        // R7 transmit flag
        tx_fill = 4'd3;            step(8'h20, 0, 0, "R7 tx fill reaches threshold");
        tx_fill = 4'd5;            step(8'h20, 0, 0, "R7 tx held without write");
        tx_fill = 4'd3; dat_wr = 1; step(8'h20, 0, 0, "R7 write at threshold keeps");
        tx_fill = 4'd5; dat_wr = 1; step(8'h00, 0, 0, "R7 write beyond threshold clears");
        tx_fill = 4'd0;

        // R8 receive flag and R9 interrupt gating
        rx_fill = 4'd2;            step(8'h08, 0, 0, "R8 rx fill reaches threshold");
        rx_fill = 4'd2; dat_rd = 1; step(8'h08, 0, 0, "R8 read at threshold keeps");
        rx_fill = 4'd0; spie = 1;  step(8'h08, 0, 0, "R9 no irq without gie");
        gie = 1;                   step(8'h08, 1, 0, "R9 irq with both enables");
        spie = 0;                  step(8'h08, 0, 0, "R9 no irq without spie");
        spie = 1; dat_rd = 1;      step(8'h00, 0, 0, "R8 read below threshold clears");
        xfer_done = 1;             step(8'h80, 1, 0, "R9 completion raises irq");
        int_ack = 1;               step(8'h00, 0, 0, "R4 ack drops irq");
        spie = 0; gie = 0;

        // R10 double speed
        sts_wr = 1; ds_wdata = 1;  step(8'h01, 0, 0, "R10 bit written, not host");
        host_mode = 1;             step(8'h01, 0, 1, "R10 active in host mode");
        sts_wr = 1; ds_wdata = 0;  step(8'h00, 0, 0, "R10 bit cleared");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule